// File: doc/BRIEF.md
# Word-Aligning Serial Deserializer

This block turns a serial bit stream into 8-bit parallel words. It runs on the fast bit clock. In single-rate mode it takes one bit per cycle. In double-rate mode it takes two bits per cycle, and `sd_a` carries the earlier of the two. Once per word period it produces a word and raises a one-cycle `word_valid` strobe. That strobe is the word-rate enable for all downstream logic.

The link may come up on an arbitrary bit boundary. Alignment logic outside this block watches the words for a known repeating training pattern. Each time it raises `slip` during a word-rate cycle, the block moves its capture window and changes which bit starts a word. The logic keeps slipping until the training pattern appears. The step taken by one slip depends on the mode. A single-rate slip rotates the word left by one bit. Double-rate slips alternate between a right rotation by one and a left rotation by three. In both modes, eight slips on an 8-bit repeating pattern bring back the original alignment.

Top module: `bitslip_deser`

## Requirements
- R1: A synchronous reset clears the history, the alignment offset and the double-rate slip phase. While reset is high, `word_q` is 0 and `word_valid` is 0. The first `word_valid` comes on the 8th rising edge after reset is released in single-rate mode, or on the 4th in double-rate mode.
- R2: In single-rate mode (`ddr_mode`=0), `sd_a` is shifted in once per cycle. A word holds 8 consecutive bits, and the earliest bit is in bit 7.
- R3: In double-rate mode (`ddr_mode`=1), each cycle shifts in `sd_a` and then `sd_b`, so `sd_a` lands one position more significant. A word is produced every 4 cycles.
- R4: In single-rate mode, each accepted slip makes later words equal to the previous alignment rotated left by one bit.
- R5: In double-rate mode, accepted slips alternate starting from reset. The first slip rotates right by one bit, the second rotates left by three bits, and the pattern repeats.
- R6: Eight consecutive accepted slips return the words to the alignment they had before the first of them, in either mode.
- R7: `slip` is sampled only on the rising edge that ends a cycle with `word_valid` high, and the new alignment applies from the next word captured. If `slip` is high when `word_valid` is low, it has no effect. A level held across several word cycles counts once per word cycle.
- R8: `word_valid` is a one-cycle pulse. After the first word it repeats every 8 cycles (single-rate) or every 4 cycles (double-rate), and `word_q` holds its value between pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous reset, active high |
| ddr_mode | input | 1 | 0: one bit per cycle, 1: two bits per cycle (static) |
| sd_a | input | 1 | Serial bit; the earlier bit in double-rate mode |
| sd_b | input | 1 | Later serial bit, used only in double-rate mode |
| slip | input | 1 | Alignment step request, sampled in word-valid cycles |
| word_q | output | 8 | Parallel word, earliest bit in bit 7 |
| word_valid | output | 1 | One-cycle strobe marking a new word |

## Verification
The bench slips a repeating pattern through all eight rotations in each mode and compares every word with a rotation model. A design that used the same slip step in both modes, or started the double-rate alternation on the wrong step, shows a wrong word on the first or second slip. A design that did not wrap the offset modulo 8 would fail the return to the original alignment. The bench also holds `slip` high across several word periods, and across the first partial word after reset. A design that sampled the request on every bit-clock edge would then slip many times instead of once per word, and one that acted during the first partial word would start from the wrong alignment. The reset-to-first-word latency and the pulse spacing are also counted, which exposes an off-by-one word counter.

// File: rtl/bitslip_deser.sv
module bitslip_deser #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ddr_mode,
  input  logic         sd_a,
  input  logic         sd_b,
  input  logic         slip,
  output logic [W-1:0] word_q,
  output logic         word_valid
);
  localparam int OW = $clog2(W);
  localparam int HW = 2 * W;

  logic [HW-1:0] hist, hist_nx;
  logic [OW-1:0] bitcnt, bitcnt_nx, off, sel;
  logic          ddr_ph, tick, take;

  assign hist_nx   = ddr_mode ? {hist[HW-3:0], sd_a, sd_b} : {hist[HW-2:0], sd_a};
  assign bitcnt_nx = bitcnt + (ddr_mode ? OW'(2) : OW'(1));
  assign tick      = (bitcnt_nx == '0);
  assign sel       = OW'(0) - off;
  assign take      = slip && word_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist       <= '0;
      bitcnt     <= '0;
      word_q     <= '0;
      word_valid <= 1'b0;
    end else begin
      hist       <= hist_nx;
      bitcnt     <= bitcnt_nx;
      word_valid <= tick;
      if (tick) word_q <= W'(hist_nx >> sel);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      off    <= '0;
      ddr_ph <= 1'b0;
    end else if (take) begin
      if (!ddr_mode)   off <= off + OW'(1);
      else if (!ddr_ph) off <= off - OW'(1);
      else             off <= off + OW'(3);
      ddr_ph <= ddr_mode ? !ddr_ph : ddr_ph;
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!word_valid && word_q == '0)); // R1
  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (rst) word_valid |=> !word_valid); // R8
  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (rst) !tick |=> $stable(word_q)); // R8
  AST_NO_SLIP_IDLE: assert property (@(posedge clk) disable iff (rst) !take |=> $stable(off) && $stable(ddr_ph)); // R7
  AST_SDR_STEP: assert property (@(posedge clk) disable iff (rst) (take && !ddr_mode) |=> off == OW'($past(off) + 1)); // R4
  AST_DDR_RIGHT: assert property (@(posedge clk) disable iff (rst) (take && ddr_mode && !ddr_ph) |=> (off == OW'($past(off) - 1) && ddr_ph)); // R5
  AST_DDR_LEFT: assert property (@(posedge clk) disable iff (rst) (take && ddr_mode && ddr_ph) |=> (off == OW'($past(off) + 3) && !ddr_ph)); // R5
endmodule

// File: tb/sim_bitslip_deser.sv
module sim_bitslip_deser;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ddr_mode = 1'b0;
  logic sd_a = 1'b0, sd_b = 1'b0, slip = 1'b0;
  logic [7:0] word_q;
  logic word_valid;
  int total = 0, bad = 0;
  logic [7:0] expq[$];

  always #5 clk = ~clk;

  bitslip_deser u0 (.clk(clk), .rst(rst), .ddr_mode(ddr_mode), .sd_a(sd_a), .sd_b(sd_b),
                    .slip(slip), .word_q(word_q), .word_valid(word_valid));

  function automatic logic [7:0] rotl(logic [7:0] v, int n);
    int k = ((n % 8) + 8) % 8;
    return 8'((v << k) | (v >> (8 - k)));
  endfunction

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_phase(bit ddr, logic [7:0] pat, logic [31:0] sched, bit pre, int nwords, string slip_tag);
    int idx = 0, off = 0, nslip = 0, widx = 0, cyc = 0, last = 0;
    bit ph = 0;
    int period = ddr ? 4 : 8;
    ddr_mode = ddr; rst = 1'b1; slip = 1'b0; sd_a = 0; sd_b = 0;
    repeat (3) @(negedge clk);
    check("R1 reset word", word_q, 0);
    check("R1 reset valid", word_valid, 0);
    rst = 1'b0;
    slip = pre;
    expq.delete();
    expq.push_back(pat);
    while (widx < nwords && cyc < 2000) begin
      sd_a = pat[7 - (idx % 8)];
      sd_b = pat[7 - ((idx + 1) % 8)];
      idx += ddr ? 2 : 1;
      @(negedge clk);
      cyc++;
      if (word_valid) begin
        string tag;
        logic [7:0] e;
        if (widx == 0) check("R1 first word latency", cyc, period);
        else check("R8 strobe spacing", cyc - last, period);
        last = cyc;
        e = expq.pop_front();
        if (nslip == 0) tag = ddr ? "R3" : "R2";
        else if (slip_tag != "") tag = slip_tag;
        else if (nslip >= 8 && (off % 8) == 0) tag = "R6";
        else tag = ddr ? "R5" : "R4";
        check(tag, word_q, e);
        slip = sched[widx];
        widx++;
        if (slip) begin
          nslip++;
          if (!ddr) off += 1;
          else begin
            off += ph ? 3 : -1;
            ph = !ph;
          end
        end
        expq.push_back(rotl(pat, off));
      end
    end
    check("R8 words seen", widx, nwords);
    slip = 1'b0;
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R4 R6: slips on words 1..9, one per word
    run_phase(1'b0, 8'b10010011, 32'h0000_03FE, 1'b0, 14, "");
    // R5 R6: DDR alternation through a full cycle
    run_phase(1'b1, 8'b00100111, 32'h0000_01FE, 1'b0, 13, "");
    // R7: level held across three word cycles, and high during the first partial word
    run_phase(1'b0, 8'hB4, 32'h0000_001C, 1'b1, 9, "R7");
    run_phase(1'b1, 8'h1E, 32'h0000_0066, 1'b1, 10, "R7");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule